// File: doc/BRIEF.md
# Timer Software Event Generator

This block is a four-channel timer whose event register lets software force hardware events. A write to the event register address produces a one-cycle pulse on each bit written as 1. Every pulse triggers the same side effect that the matching hardware event would cause. Because the pulse only lasts for the write cycle, no bit needs to be cleared by software. Writing a 0 bit does nothing.

The forced events are:
- **Update:** reinitialises the counter and clears the prescaler count.
- **Channel:** raises that channel's flag. On a channel set as input, it also captures the counter and can report an overcapture.
- **Commutation:** moves preloaded channel controls into their active copies.
- **Trigger:** raises the trigger flag.
- **Break:** raises the break flag and drops the main output enable.

The counter runs behind a programmable prescaler in one of three modes: edge-up, edge-down or center-aligned. Its phase register has two states:
- **PH_UP:** the counter steps up. In center mode, when it reaches the reload value it takes the transition *peak*, moves to PH_DOWN and raises the update flag.
- **PH_DOWN:** the counter steps down. In center mode, when it reaches 0 it takes the transition *valley*, returns to PH_UP and raises the update flag.

In edge modes the phase simply follows the direction bit. A forced update moves the phase to PH_DOWN in edge-down mode and to PH_UP in every other mode.

Configuration is written through the same port. All addresses are byte offsets:

| Offset | Contents |
|---|---|
| 0x00 | Control: bit0 run, bit1 down, bit2 center, bit3 preload-control |
| 0x04 | Interrupt enable, one bit per flag |
| 0x08 | Channel input select, bits 3:0 |
| 0x0C | Status clear |
| 0x14 | Events |
| 0x18 | Preloaded channel controls, 15 bits |
| 0x1C | Prescaler ratio |
| 0x20 | Reload value |
| 0x24 | Main output enable, bit0 |

Top module: `tmr_evt_gen`

## Requirements
- R1: After reset, the counter, flags, overcapture bits, capture registers, main output enable, active controls and irq are all 0.
- R2: When run is set, the counter steps once every (ratio+1) cycles. In up mode it wraps from the reload value to 0. In down mode it wraps from 0 to the reload value. In center mode it turns at the reload value and at 0. Each wrap or turn sets flag bit 0.
- R3: Event bit 0 sets the counter to 0 in up or center mode, or to the reload value in edge-down mode. It also clears the prescaler count and sets flag bit 0. In that cycle it replaces the count step.
- R4: Event bit k (1..4) on an output channel k sets flag bit k and leaves that channel's capture register and overcapture bit unchanged.
- R5: Event bit k on an input channel copies the counter value from before the edge into capture register k and sets flag bit k.
- R6: Event bit k on an input channel whose flag bit k is already 1 sets overcapture bit k-1.
- R7: Event bit 6 sets flag bit 6 (trigger).
- R8: Event bit 7 clears the main output enable and sets flag bit 7 (break).
- R9: Event bit 5 sets flag bit 5. When preload-control is 1, it also copies the preloaded controls to the active controls. When preload-control is 0, a write to the preload register updates the active controls at once.
- R10: A status-clear write clears every flag whose data bit 7:0 is 0 and every overcapture bit whose data bit 11:8 is 0. A hardware set in the same cycle wins.
- R11: irq is 1 exactly when a flag and its enable bit are both 1.
- R12: All event bits written together take effect in the same cycle. An event write of 0 changes nothing.
- R13: A write to an address outside the map changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Byte offset |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Counter value |
| flags_o | output | 8 | Flags: 0 update, 4..1 channels, 5 commutation, 6 trigger, 7 break |
| ovc_o | output | 4 | Overcapture bits |
| ccr_o | output | 64 | Capture registers, channel 1 in bits 15:0 |
| main_oe_o | output | 1 | Main output enable |
| act_ctl_o | output | 15 | Active channel controls |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong phase state or prescaler count shows on cnt_o within one prescaler period, as a wrong turn point or a step taken at the wrong time. A corrupted flag or overcapture bit reaches flags_o, ovc_o and irq_o on the edge after the write that caused it. The reference model is compared on every clock, so such an error is caught within a cycle of first becoming visible.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_IEN    = 8'h04;
    localparam logic [7:0] A_CHMODE = 8'h08;
    localparam logic [7:0] A_STAT   = 8'h0C;
    localparam logic [7:0] A_EVT    = 8'h14;
    localparam logic [7:0] A_CHCTL  = 8'h18;
    localparam logic [7:0] A_PSC    = 8'h1C;
    localparam logic [7:0] A_ARR    = 8'h20;
    localparam logic [7:0] A_OUTEN  = 8'h24;

    typedef enum logic {
        PH_UP   = 1'b0,
        PH_DOWN = 1'b1
    } phase_t;
endpackage

// File: rtl/tmr_evt_timebase.sv
module tmr_evt_timebase
    import tmr_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             down_i,
    input  logic             center_i,
    input  logic             ug_i,
    input  logic [CNT_W-1:0] psc_i,
    input  logic [CNT_W-1:0] arr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    phase_t           ph_q, ph_d;
    logic [CNT_W-1:0] pc_q;
    logic [CNT_W-1:0] cnt_d;
    logic             tick;

    assign tick = run_i && (pc_q == psc_i);

    // prescaler count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pc_q <= '0;
        else if (ug_i)   pc_q <= '0;
        else if (run_i)  pc_q <= tick ? '0 : pc_q + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= PH_UP;
            cnt_o <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_o <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        ph_d   = ph_q;
        cnt_d  = cnt_o;
        wrap_o = 1'b0;
        if (ug_i) begin
            cnt_d = (down_i && !center_i) ? arr_i : '0;
            ph_d  = (down_i && !center_i) ? PH_DOWN : PH_UP;
        end else if (tick) begin
            if (!center_i) begin
                ph_d = down_i ? PH_DOWN : PH_UP;
                if (down_i) begin
                    if (cnt_o == '0) begin
                        cnt_d  = arr_i;
                        wrap_o = 1'b1;
                    end else begin
                        cnt_d = cnt_o - 1'b1;
                    end
                end else if (cnt_o >= arr_i) begin
                    cnt_d  = '0;
                    wrap_o = 1'b1;
                end else begin
                    cnt_d = cnt_o + 1'b1;
                end
            end else begin
                unique case (ph_q)
                    PH_UP: begin
                        if (cnt_o >= arr_i) begin
                            ph_d   = PH_DOWN;
                            wrap_o = 1'b1;
                            cnt_d  = (arr_i == '0) ? '0 : arr_i - 1'b1;
                        end else begin
                            cnt_d = cnt_o + 1'b1;
                        end
                    end
                    PH_DOWN: begin
                        if (cnt_o == '0) begin
                            ph_d   = PH_UP;
                            wrap_o = 1'b1;
                            cnt_d  = (arr_i == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
                        end else begin
                            cnt_d = cnt_o - 1'b1;
                        end
                    end
                    default: ph_d = PH_UP;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_evt_chan.sv
module tmr_evt_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_i,
    input  logic             is_in_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             clr_i,
    input  logic             keep_flag_i,
    input  logic             keep_ovc_i,
    output logic             flag_o,
    output logic             ovc_o,
    output logic [CNT_W-1:0] ccr_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            ovc_o  <= 1'b0;
            ccr_o  <= '0;
        end else begin
            if (gen_i)                      flag_o <= 1'b1;
            else if (clr_i && !keep_flag_i) flag_o <= 1'b0;

            if (gen_i && is_in_i && flag_o) ovc_o <= 1'b1;
            else if (clr_i && !keep_ovc_i)  ovc_o <= 1'b0;

            if (gen_i && is_in_i)           ccr_o <= cnt_i;
        end
    end
endmodule

// File: rtl/tmr_evt_gen.sv
module tmr_evt_gen
    import tmr_evt_pkg::*;
#(
    parameter  int CNT_W  = 16,
    parameter  int NCH    = 4,
    parameter  int NCOMP  = 3,
    parameter  int CTL_W  = 5,
    parameter  int ADDR_W = 8,
    parameter  int DATA_W = 16,
    localparam int FLAG_W = NCH + 4,
    localparam int ACT_W  = NCOMP * CTL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [FLAG_W-1:0]    flags_o,
    output logic [NCH-1:0]       ovc_o,
    output logic [NCH*CNT_W-1:0] ccr_o,
    output logic                 main_oe_o,
    output logic [ACT_W-1:0]     act_ctl_o,
    output logic                 irq_o
);
    localparam int B_COM = NCH + 1;
    localparam int B_TRG = NCH + 2;
    localparam int B_BRK = NCH + 3;

    logic              run_q, down_q, center_q, ccpc_q;
    logic [FLAG_W-1:0] ien_q;
    logic [NCH-1:0]    chin_q;
    logic [ACT_W-1:0]  pre_q;
    logic [CNT_W-1:0]  psc_q, arr_q;
    logic              upd_f, com_f, trg_f, brk_f;
    logic [NCH-1:0]    ch_flag;
    logic [FLAG_W-1:0] evt;
    logic              stat_wr, wrap;

    function automatic logic hit(input logic [ADDR_W-1:0] a);
        return wr_en && (wr_addr == a);
    endfunction

    assign evt     = hit(A_EVT) ? wr_data[FLAG_W-1:0] : '0;
    assign stat_wr = hit(A_STAT);

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0; down_q <= 1'b0; center_q <= 1'b0; ccpc_q <= 1'b0;
            ien_q <= '0; chin_q <= '0; pre_q <= '0;
            psc_q <= '0; arr_q <= '1;
        end else begin
            if (hit(A_CTRL)) begin
                run_q    <= wr_data[0];
                down_q   <= wr_data[1];
                center_q <= wr_data[2];
                ccpc_q   <= wr_data[3];
            end
            if (hit(A_IEN))    ien_q  <= wr_data[FLAG_W-1:0];
            if (hit(A_CHMODE)) chin_q <= wr_data[NCH-1:0];
            if (hit(A_CHCTL))  pre_q  <= wr_data[ACT_W-1:0];
            if (hit(A_PSC))    psc_q  <= wr_data[CNT_W-1:0];
            if (hit(A_ARR))    arr_q  <= wr_data[CNT_W-1:0];
        end
    end

    // update, commutation, trigger and break state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_f <= 1'b0; com_f <= 1'b0; trg_f <= 1'b0; brk_f <= 1'b0;
            main_oe_o <= 1'b0;
            act_ctl_o <= '0;
        end else begin
            if (evt[0] || wrap)              upd_f <= 1'b1;
            else if (stat_wr && !wr_data[0]) upd_f <= 1'b0;

            if (evt[B_COM])                      com_f <= 1'b1;
            else if (stat_wr && !wr_data[B_COM]) com_f <= 1'b0;

            if (evt[B_TRG])                      trg_f <= 1'b1;
            else if (stat_wr && !wr_data[B_TRG]) trg_f <= 1'b0;

            if (evt[B_BRK])                      brk_f <= 1'b1;
            else if (stat_wr && !wr_data[B_BRK]) brk_f <= 1'b0;

            if (evt[B_BRK])         main_oe_o <= 1'b0;
            else if (hit(A_OUTEN))  main_oe_o <= wr_data[0];

            if (evt[B_COM] && ccpc_q)           act_ctl_o <= pre_q;
            else if (hit(A_CHCTL) && !ccpc_q)   act_ctl_o <= wr_data[ACT_W-1:0];
        end
    end

    tmr_evt_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_q),
        .down_i   (down_q),
        .center_i (center_q),
        .ug_i     (evt[0]),
        .psc_i    (psc_q),
        .arr_i    (arr_q),
        .cnt_o    (cnt_o),
        .wrap_o   (wrap)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_evt_chan #(.CNT_W(CNT_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .gen_i       (evt[1+i]),
            .is_in_i     (chin_q[i]),
            .cnt_i       (cnt_o),
            .clr_i       (stat_wr),
            .keep_flag_i (wr_data[1+i]),
            .keep_ovc_i  (wr_data[FLAG_W+i]),
            .flag_o      (ch_flag[i]),
            .ovc_o       (ovc_o[i]),
            .ccr_o       (ccr_o[i*CNT_W +: CNT_W])
        );
    end

    assign flags_o = {brk_f, trg_f, com_f, ch_flag, upd_f};
    assign irq_o   = |(flags_o & ien_q);
endmodule

// File: rtl/tmr_evt_gen_chk.sv
module tmr_evt_gen_chk
    import tmr_evt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [7:0]           wr_addr,
    input logic [15:0]          wr_data,
    input logic [CNT_W-1:0]     cnt,
    input logic [NCH+3:0]       flags,
    input logic [NCH-1:0]       ovc,
    input logic [NCH*CNT_W-1:0] ccr,
    input logic                 moe,
    input logic [NCH-1:0]       chin,
    input logic                 down,
    input logic                 center
);
    logic ev_hit;
    assign ev_hit = wr_en && (wr_addr == A_EVT);

    p_upd_reinit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hit && wr_data[0] && (center || !down) |=> (cnt == '0) && flags[0]);

    p_trg_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hit && wr_data[NCH+2] |=> flags[NCH+2]);

    p_brk_moe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hit && wr_data[NCH+3] |=> !moe && flags[NCH+3]);

    p_com_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hit && wr_data[NCH+1] |=> flags[NCH+1]);

    for (genvar i = 0; i < NCH; i++) begin : g_c
        p_out_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ev_hit && wr_data[1+i] && !chin[i]
            |=> $stable(ccr[i*CNT_W +: CNT_W]) && flags[1+i]);

        p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ev_hit && wr_data[1+i] && chin[i]
            |=> (ccr[i*CNT_W +: CNT_W] == $past(cnt)) && flags[1+i]);

        p_overcap_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ev_hit && wr_data[1+i] && chin[i] && flags[1+i] |=> ovc[i]);
    end
endmodule

bind tmr_evt_gen tmr_evt_gen_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cnt     (cnt_o),
    .flags   (flags_o),
    .ovc     (ovc_o),
    .ccr     (ccr_o),
    .moe     (main_oe_o),
    .chin    (chin_q),
    .down    (down_q),
    .center  (center_q)
);

// File: tb/tmr_evt_gen_bench.sv
module tmr_evt_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] cnt_o;
    logic [7:0]  flags_o;
    logic [3:0]  ovc_o;
    logic [63:0] ccr_o;
    logic        main_oe_o;
    logic [14:0] act_ctl_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit chk_on = 0;

    always #2 clk = ~clk;

    tmr_evt_gen u_tmr_evt_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_o(cnt_o), .flags_o(flags_o), .ovc_o(ovc_o), .ccr_o(ccr_o),
        .main_oe_o(main_oe_o), .act_ctl_o(act_ctl_o), .irq_o(irq_o)
    );

    // reference model state
    int unsigned m_cnt, m_pc, m_psc, m_arr;
    bit          m_ph, m_run, m_down, m_center, m_ccpc, m_moe;
    bit   [7:0]  m_flags, m_ien;
    bit   [3:0]  m_ovc, m_chin;
    bit   [14:0] m_pre, m_act;
    int unsigned m_ccr [4];
    // scratch
    bit   [7:0]  ev, nf;
    bit   [3:0]  novc;
    bit          tick, wrap, nph;
    int unsigned ncnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pc = 0; m_psc = 0; m_arr = 16'hFFFF; m_ph = 0;
            m_run = 0; m_down = 0; m_center = 0; m_ccpc = 0; m_moe = 0;
            m_flags = 0; m_ien = 0; m_ovc = 0; m_chin = 0; m_pre = 0; m_act = 0;
            foreach (m_ccr[c]) m_ccr[c] = 0;
        end else begin
            ev   = (wr_en && wr_addr == 8'h14) ? wr_data[7:0] : 8'h00;
            tick = m_run && (m_pc == m_psc);
            wrap = 0; ncnt = m_cnt; nph = m_ph;
            if (ev[0]) begin
                ncnt = (m_down && !m_center) ? m_arr : 0;
                nph  = m_down && !m_center;
            end else if (tick) begin
                if (!m_center) begin
                    nph = m_down;
                    if (m_down) begin
                        if (m_cnt == 0) begin ncnt = m_arr; wrap = 1; end
                        else ncnt = m_cnt - 1;
                    end else begin
                        if (m_cnt >= m_arr) begin ncnt = 0; wrap = 1; end
                        else ncnt = m_cnt + 1;
                    end
                end else if (!m_ph) begin
                    if (m_cnt >= m_arr) begin nph = 1; wrap = 1; ncnt = (m_arr == 0) ? 0 : m_arr - 1; end
                    else ncnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin nph = 0; wrap = 1; ncnt = (m_arr == 0) ? 0 : 1; end
                    else ncnt = m_cnt - 1;
                end
            end
            if (ev[0]) m_pc = 0;
            else if (m_run) m_pc = tick ? 0 : m_pc + 1;

            nf = m_flags; novc = m_ovc;
            if (wr_en && wr_addr == 8'h0C) begin
                nf = nf & wr_data[7:0];
                novc = novc & wr_data[11:8];
            end
            if (ev[0] || wrap) nf[0] = 1;
            for (int c = 0; c < 4; c++) begin
                if (ev[1+c]) begin
                    if (m_chin[c]) begin
                        m_ccr[c] = m_cnt;
                        if (m_flags[1+c]) novc[c] = 1;
                    end
                    nf[1+c] = 1;
                end
            end
            if (ev[5]) begin nf[5] = 1; if (m_ccpc) m_act = m_pre; end
            if (ev[6]) nf[6] = 1;
            if (wr_en && wr_addr == 8'h24) m_moe = wr_data[0];
            if (ev[7]) begin nf[7] = 1; m_moe = 0; end
            if (wr_en && wr_addr == 8'h18) begin
                m_pre = wr_data[14:0];
                if (!m_ccpc) m_act = wr_data[14:0];
            end
            if (wr_en && wr_addr == 8'h00) begin
                m_run = wr_data[0]; m_down = wr_data[1];
                m_center = wr_data[2]; m_ccpc = wr_data[3];
            end
            if (wr_en && wr_addr == 8'h04) m_ien  = wr_data[7:0];
            if (wr_en && wr_addr == 8'h08) m_chin = wr_data[3:0];
            if (wr_en && wr_addr == 8'h1C) m_psc  = wr_data;
            if (wr_en && wr_addr == 8'h20) m_arr  = wr_data;
            m_cnt = ncnt; m_ph = nph; m_flags = nf; m_ovc = novc;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on) begin
            chk("R2 R3 counter", cnt_o, m_cnt);
            chk("R4 R5 R6 R7 R8 R9 R10 flags", flags_o, m_flags);
            chk("R6 R10 overcapture", ovc_o, m_ovc);
            for (int c = 0; c < 4; c++)
                chk("R5 capture", ccr_o[c*16 +: 16], m_ccr[c]);
            chk("R8 main enable", main_oe_o, m_moe);
            chk("R9 active controls", act_ctl_o, m_act);
            chk("R11 irq", irq_o, |(m_flags & m_ien));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    logic [15:0] snap;
    logic [7:0]  fsnap;

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        chk_on = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 counter", cnt_o, 0);
        chk("R1 flags", flags_o, 0);
        chk("R1 capture", ccr_o, 0);
        chk("R1 enable", {main_oe_o, act_ctl_o, irq_o, ovc_o}, 0);

        // R2 up counting with prescaler
        wr(8'h20, 16'd5);
        wr(8'h1C, 16'd1);
        wr(8'h00, 16'h0001);
        idle(30);
        chk("R2 wrap flag", flags_o[0], 1);
        wr(8'h00, 16'h0000);
        // R10 clear update flag
        wr(8'h0C, 16'h0FFE);
        chk("R10 cleared", flags_o[0], 0);

        // R4 output channel
        snap = ccr_o[15:0];
        wr(8'h14, 16'h0002);
        chk("R4 flag", flags_o[1], 1);
        chk("R4 capture kept", ccr_o[15:0], snap);
        chk("R4 no overcapture", ovc_o[0], 0);

        // R5 R6 input channels
        wr(8'h08, 16'h000E);
        wr(8'h00, 16'h0001);
        idle(5);
        @(negedge clk);
        snap = cnt_o;
        wr_en = 1'b1; wr_addr = 8'h14; wr_data = 16'h0004;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        chk("R5 capture", ccr_o[31:16], snap);
        chk("R5 flag", flags_o[2], 1);
        chk("R6 no overcapture yet", ovc_o[1], 0);
        idle(3);
        wr(8'h14, 16'h0004);
        chk("R6 overcapture", ovc_o[1], 1);

        // R3 update in up, down, center modes
        idle(4);
        wr(8'h14, 16'h0001);
        chk("R3 up reinit", cnt_o, 0);
        chk("R3 update flag", flags_o[0], 1);
        wr(8'h00, 16'h0003);
        idle(7);
        wr(8'h14, 16'h0001);
        chk("R3 down reinit", cnt_o, 5);
        wr(8'h00, 16'h0005);
        wr(8'h1C, 16'd0);
        idle(40);
        wr(8'h14, 16'h0001);
        chk("R3 center reinit", cnt_o, 0);
        idle(9);

        // R7 trigger, R8 break
        wr(8'h14, 16'h0040);
        chk("R7 trigger", flags_o[6], 1);
        wr(8'h24, 16'h0001);
        chk("R8 enable on", main_oe_o, 1);
        wr(8'h14, 16'h0080);
        chk("R8 enable off", main_oe_o, 0);
        chk("R8 break flag", flags_o[7], 1);

        // R9 commutation
        wr(8'h00, 16'h0000);
        wr(8'h18, 16'h1234);
        chk("R9 direct", act_ctl_o, 15'h1234);
        wr(8'h00, 16'h0008);
        wr(8'h18, 16'h0555);
        chk("R9 held", act_ctl_o, 15'h1234);
        wr(8'h14, 16'h0020);
        chk("R9 transfer", act_ctl_o, 15'h0555);
        chk("R9 flag", flags_o[5], 1);

        // R11 irq
        wr(8'h0C, 16'h0040);
        wr(8'h04, 16'h0040);
        chk("R11 irq on", irq_o, 1);
        wr(8'h0C, 16'h0000);
        chk("R11 irq off", irq_o, 0);
        chk("R10 all cleared", {ovc_o, flags_o}, 0);

        // R12 zero write, then all events together
        fsnap = flags_o; snap = cnt_o;
        wr(8'h14, 16'h0000);
        chk("R12 zero write flags", flags_o, fsnap);
        chk("R12 zero write counter", cnt_o, snap);
        wr(8'h24, 16'h0001);
        wr(8'h14, 16'h00FF);
        chk("R12 all flags", flags_o, 8'hFF);
        chk("R12 break with rest", main_oe_o, 0);
        chk("R12 counter", cnt_o, 0);

        // R13 unmapped address
        fsnap = flags_o;
        wr(8'h10, 16'h0000);
        wr(8'h30, 16'hFFFF);
        chk("R13 flags", flags_o, fsnap);
        chk("R13 controls", act_ctl_o, 15'h0555);

        // center-mode run with a status clear racing wraps (R10)
        wr(8'h00, 16'h0005);
        for (int k = 0; k < 20; k++) begin
            wr(8'h0C, 16'h0000);
            idle(k % 3);
        end
        idle(5);
        chk_on = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule